// File: doc/BRIEF.md
# ROM Patch Address Redirect Unit

This block sits beside a CPU's instruction-fetch path and lets faulty code held in mask ROM be bypassed. Software loads up to two 16-bit patch addresses through a byte-wide register port. Each address has its own enable. During an opcode fetch, if the fetch address equals an enabled patch address, the block raises a redirect in the same cycle. It also replaces the fetch address with a fixed vector address, and the CPU takes the patch routine from there. The patch routine ends with a jump back into the main program.

One selector bit places both vectors together, either in a RAM window or in a ROM window. The vectors for the two slots are spaced a fixed stride apart. When a slot is disabled it never redirects, so its vector area stays usable as ordinary memory. Data and operand accesses never trigger a redirect, because the comparison only counts when the opcode-fetch strobe is high.

Top module: `patch_redirect_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00 and no redirect occurs for any fetch.
- R2: The match bytes sit at fixed offsets: 0x0FF8 holds the slot A high byte, 0x0FF9 the slot A low byte, 0x0FFA the slot B high byte and 0x0FFB the slot B low byte. A write updates the addressed byte at the next clock edge, and a read returns the current byte in the same cycle.
- R3: The control byte is at 0x0FFC. Bit 0 enables slot A, bit 1 enables slot B and bit 2 is the vector selector. Bits 7:3 always read 0, and a read of any address outside 0x0FF8..0x0FFC returns 0x00.
- R4: When fetch_op is 1, an enabled slot's stored address equals fetch_pc, redirect is 1 in the same cycle and fetch_addr_out carries that slot's vector.
- R5: A slot whose enable bit is 0 never causes a redirect.
- R6: When fetch_op is 0, redirect is 0 and fetch_addr_out equals fetch_pc, even if the address matches an enabled slot.
- R7: With the selector at 0, slot A vectors to 0x0100 and slot B to 0x0120. With the selector at 1, they vector to 0xF100 and 0xF120.
- R8: When both slots are enabled and hold the same address, slot A's vector is the one used.
- R9: Without a redirect, fetch_addr_out equals fetch_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register port address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| fetch_pc | input | 16 | Current fetch address from the CPU |
| fetch_op | input | 1 | High when the access is an opcode fetch |
| redirect | output | 1 | High when the fetch is being replaced by a vector |
| fetch_addr_out | output | 16 | Vector on redirect, otherwise fetch_pc |

## Verification
Some properties are checked by assertions on every cycle. A redirect only ever occurs with the opcode-fetch strobe high. Nothing redirects while both enables are clear. Every redirected address lands inside the window picked by the selector. A slot A hit always yields the slot A vector. A control write lands on the next edge, and the control byte holds steady otherwise. Other behaviour can only be shown by the bench's scenarios, where the exact vector value is compared against the selector. These cover the readback of the register map, the masking of the unused control bits, a disabled slot's address being ignored while the other slot is live, and the same-address priority case. Random mixes of register writes and fetches aimed at the stored addresses complete the coverage.

// File: rtl/patch_pkg.sv
// Shared constants for the ROM patch redirect unit.
// Assumes a 16-bit address space and an 8-bit register port.
package patch_pkg;
    localparam int PATCH_AW    = 16;
    localparam int PATCH_DW    = 8;
    localparam int PATCH_SLOTS = 2;
    localparam logic [PATCH_AW-1:0] PATCH_REG_BASE = 16'h0FF8;
    localparam logic [PATCH_AW-1:0] PATCH_RAM_VEC  = 16'h0100;
    localparam logic [PATCH_AW-1:0] PATCH_ROM_VEC  = 16'hF100;
    localparam logic [PATCH_AW-1:0] PATCH_VEC_STEP = 16'h0020;
endpackage

// File: rtl/patch_regs.sv
// Register file of the patch unit: per-slot match addresses stored
// big-endian (high byte at the lower offset), followed by one control byte
// holding the slot enables and the vector selector.
// Assumes AW is a multiple of DW and NS+1 <= DW.
module patch_regs #(
    parameter int AW = patch_pkg::PATCH_AW,
    parameter int DW = patch_pkg::PATCH_DW,
    parameter int NS = patch_pkg::PATCH_SLOTS,
    parameter logic [AW-1:0] REG_BASE = patch_pkg::PATCH_REG_BASE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_we,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [NS-1:0][AW-1:0] slot_addr,
    output logic [NS-1:0]         slot_en,
    output logic                  vec_sel
);
    localparam int BPS      = AW / DW;
    localparam int NMATCH   = NS * BPS;
    localparam int CTRL_OFS = NMATCH;
    localparam int CW       = NS + 1;

    logic [DW-1:0] match_q [NMATCH];
    logic [CW-1:0] ctrl_q;
    logic [AW-1:0] ofs;
    logic          in_range;

    // Decode the offset of the register port address from the block base.
    always_comb begin
        ofs      = bus_addr - REG_BASE;
        in_range = (ofs <= AW'(CTRL_OFS));
    end

    // Store written bytes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NMATCH; i++) match_q[i] <= '0;
            ctrl_q <= '0;
        end else if (bus_we && in_range) begin
            for (int i = 0; i < NMATCH; i++)
                if (ofs == AW'(i)) match_q[i] <= bus_wdata;
            if (ofs == AW'(CTRL_OFS)) ctrl_q <= bus_wdata[CW-1:0];
        end
    end

    // Return the addressed byte, unused control bits forced low.
    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            for (int i = 0; i < NMATCH; i++)
                if (ofs == AW'(i)) bus_rdata = match_q[i];
            if (ofs == AW'(CTRL_OFS)) bus_rdata = DW'(ctrl_q);
        end
    end

    // Assemble each slot's address from its bytes, high byte first.
    always_comb begin
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < BPS; k++)
                slot_addr[s][(BPS-1-k)*DW +: DW] = match_q[s*BPS + k];
        slot_en = ctrl_q[NS-1:0];
        vec_sel = ctrl_q[NS];
    end

    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && $past(bus_addr) == REG_BASE + AW'(CTRL_OFS))
        |-> ({vec_sel, slot_en} == $past(bus_wdata[CW-1:0]))); // R2
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_we)) |-> $stable({vec_sel, slot_en})); // R2
    AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_BASE + AW'(CTRL_OFS)) |-> (bus_rdata[DW-1:CW] == '0)); // R3
endmodule

// File: rtl/patch_slot_cmp.sv
// One patch slot comparator: flags a hit when an opcode fetch address equals
// the slot's stored address and the slot is enabled. Purely combinational.
module patch_slot_cmp #(
    parameter int AW = patch_pkg::PATCH_AW
) (
    input  logic [AW-1:0] fetch_pc,
    input  logic          fetch_op,
    input  logic [AW-1:0] match_addr,
    input  logic          enable,
    output logic          hit
);
    // Qualify the address compare by the enable and the opcode strobe.
    always_comb hit = fetch_op && enable && (fetch_pc == match_addr);
endmodule

// File: rtl/patch_vector_sel.sv
// Picks the winning slot (lowest index first) and forms the vector inside the
// RAM or ROM window; otherwise passes the fetch address through.
module patch_vector_sel #(
    parameter int AW = patch_pkg::PATCH_AW,
    parameter int NS = patch_pkg::PATCH_SLOTS,
    parameter logic [AW-1:0] RAM_VEC  = patch_pkg::PATCH_RAM_VEC,
    parameter logic [AW-1:0] ROM_VEC  = patch_pkg::PATCH_ROM_VEC,
    parameter logic [AW-1:0] VEC_STEP = patch_pkg::PATCH_VEC_STEP
) (
    input  logic [NS-1:0] hit,
    input  logic          vec_sel,
    input  logic [AW-1:0] fetch_pc,
    output logic          redirect,
    output logic [AW-1:0] addr_out
);
    int            win;
    logic [AW-1:0] base;

    // Priority encode so the lowest slot index wins.
    always_comb begin
        win = 0;
        for (int s = NS - 1; s >= 0; s--)
            if (hit[s]) win = s;
    end

    // Form the vector in the selected window or pass the PC through.
    always_comb begin
        base     = vec_sel ? ROM_VEC : RAM_VEC;
        redirect = |hit;
        addr_out = redirect ? (base + AW'(win) * VEC_STEP) : fetch_pc;
    end
endmodule

// File: rtl/patch_redirect_unit.sv
// Top of the ROM patch redirect unit: register file, one comparator per
// slot, and the vector selector. The redirect is combinational in the fetch
// cycle; register writes take effect at the next clock edge.
module patch_redirect_unit #(
    parameter int AW = patch_pkg::PATCH_AW,
    parameter int DW = patch_pkg::PATCH_DW,
    parameter int NS = patch_pkg::PATCH_SLOTS,
    parameter logic [AW-1:0] REG_BASE = patch_pkg::PATCH_REG_BASE,
    parameter logic [AW-1:0] RAM_VEC  = patch_pkg::PATCH_RAM_VEC,
    parameter logic [AW-1:0] ROM_VEC  = patch_pkg::PATCH_ROM_VEC,
    parameter logic [AW-1:0] VEC_STEP = patch_pkg::PATCH_VEC_STEP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   reg_addr,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [15:0]   fetch_pc,
    input  logic          fetch_op,
    output logic          redirect,
    output logic [15:0]   fetch_addr_out
);
    logic [NS-1:0][AW-1:0] slot_addr;
    logic [NS-1:0]         slot_en;
    logic [NS-1:0]         slot_hit;
    logic                  vec_sel;
    logic [AW-1:0]         vec_rel;

    patch_regs #(.AW(AW), .DW(DW), .NS(NS), .REG_BASE(REG_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(reg_addr), .bus_we(reg_we), .bus_wdata(reg_wdata),
        .bus_rdata(reg_rdata),
        .slot_addr(slot_addr), .slot_en(slot_en), .vec_sel(vec_sel)
    );

    for (genvar s = 0; s < NS; s++) begin : g_slot
        patch_slot_cmp #(.AW(AW)) u_cmp (
            .fetch_pc(fetch_pc), .fetch_op(fetch_op),
            .match_addr(slot_addr[s]), .enable(slot_en[s]),
            .hit(slot_hit[s])
        );
    end

    patch_vector_sel #(.AW(AW), .NS(NS), .RAM_VEC(RAM_VEC), .ROM_VEC(ROM_VEC),
                       .VEC_STEP(VEC_STEP)) u_vec (
        .hit(slot_hit), .vec_sel(vec_sel), .fetch_pc(fetch_pc),
        .redirect(redirect), .addr_out(fetch_addr_out)
    );

    // Offset of the output address from the selected window, for checking.
    always_comb vec_rel = fetch_addr_out - (vec_sel ? ROM_VEC : RAM_VEC);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (slot_en == '0 && !redirect)); // R1
    AST_REDIRECT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> fetch_op); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en == '0) |-> !redirect); // R5
    AST_VEC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (vec_rel < AW'(NS) * VEC_STEP)); // R7
    AST_SLOT_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        slot_hit[0] |-> (fetch_addr_out == (vec_sel ? ROM_VEC : RAM_VEC))); // R8
endmodule

// File: tb/tb_patch_redirect_unit.sv
module tb_patch_redirect_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] reg_addr = 0;
    logic        reg_we = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [15:0] fetch_pc = 0;
    logic        fetch_op = 0;
    logic        redirect;
    logic [15:0] fetch_addr_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_byte [4];
    logic [2:0] m_ctrl;

    patch_redirect_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_pc(fetch_pc),
        .fetch_op(fetch_op), .redirect(redirect), .fetch_addr_out(fetch_addr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] slot_val(int s);
        return {m_byte[2*s], m_byte[2*s+1]};
    endfunction

    function automatic logic exp_redirect(logic [15:0] pc, logic op);
        return op && ((m_ctrl[0] && pc == slot_val(0)) || (m_ctrl[1] && pc == slot_val(1)));
    endfunction

    function automatic logic [15:0] exp_addr(logic [15:0] pc, logic op);
        logic [15:0] base;
        base = m_ctrl[2] ? 16'hF100 : 16'h0100;
        if (!op) return pc;
        if (m_ctrl[0] && pc == slot_val(0)) return base;
        if (m_ctrl[1] && pc == slot_val(1)) return base + 16'h0020;
        return pc;
    endfunction

    function automatic logic [7:0] exp_rdata(logic [15:0] a);
        if (a >= 16'h0FF8 && a <= 16'h0FFB) return m_byte[a - 16'h0FF8];
        if (a == 16'h0FFC) return {5'b0, m_ctrl};
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a >= 16'h0FF8 && a <= 16'h0FFB) m_byte[a - 16'h0FF8] = d;
        if (a == 16'h0FFC) m_ctrl = d[2:0];
    endtask

    task automatic rd_check(string tag, logic [15:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {8'h00, reg_rdata}, {8'h00, exp_rdata(a)});
    endtask

    task automatic fetch_check(string tag, logic [15:0] pc, logic op);
        @(negedge clk);
        fetch_pc = pc; fetch_op = op;
        #1;
        check(tag, {15'b0, redirect}, {15'b0, exp_redirect(pc, op)});
        check(tag, fetch_addr_out, exp_addr(pc, op));
        fetch_op = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < 4; i++) m_byte[i] = 0;
        m_ctrl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int a = 16'h0FF8; a <= 16'h0FFC; a++) rd_check("R1 reset read", 16'(a));
        fetch_check("R1 no redirect after reset", 16'h0000, 1);
        // R3: unmapped addresses read zero
        rd_check("R3 below map", 16'h0FF7);
        rd_check("R3 above map", 16'h0FFD);

        // R2: map and readback
        wr(16'h0FF8, 8'h12); wr(16'h0FF9, 8'h34);
        wr(16'h0FFA, 8'hAB); wr(16'h0FFB, 8'hCD);
        for (int a = 16'h0FF8; a <= 16'h0FFB; a++) rd_check("R2 readback", 16'(a));

        // R5: both disabled
        fetch_check("R5 disabled slot A", 16'h1234, 1);
        fetch_check("R5 disabled slot B", 16'hABCD, 1);

        // R3: unused control bits read zero
        wr(16'h0FFC, 8'hFF);
        rd_check("R3 ctrl mask", 16'h0FFC);

        // R4 R7: slot A only, RAM window
        wr(16'h0FFC, 8'h01);
        fetch_check("R4 R7 slot A RAM", 16'h1234, 1);
        fetch_check("R5 slot B off", 16'hABCD, 1);
        fetch_check("R6 non-fetch ignored", 16'h1234, 0);
        fetch_check("R9 pass-through", 16'h1235, 1);

        // R7: ROM window
        wr(16'h0FFC, 8'h07);
        fetch_check("R7 slot A ROM", 16'h1234, 1);
        fetch_check("R7 slot B ROM", 16'hABCD, 1);
        fetch_check("R6 non-fetch slot B", 16'hABCD, 0);
        wr(16'h0FFC, 8'h03);
        fetch_check("R7 slot B RAM", 16'hABCD, 1);

        // R8: same address in both slots
        wr(16'h0FFA, 8'h12); wr(16'h0FFB, 8'h34);
        fetch_check("R8 slot A wins", 16'h1234, 1);
        wr(16'h0FFC, 8'h06);
        fetch_check("R8 slot B alone", 16'h1234, 1);

        // Random mix of writes and fetches
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [15:0] pc;
            kind = int'($urandom_range(0, 9));
            if (kind < 3) begin
                wr(16'h0FF8 + 16'($urandom_range(0, 4)), 8'($urandom));
            end else if (kind < 4) begin
                rd_check("R2 R3 random read", 16'h0FF6 + 16'($urandom_range(0, 8)));
            end else begin
                case ($urandom_range(0, 2))
                    0: pc = slot_val(0);
                    1: pc = slot_val(1);
                    default: pc = 16'($urandom);
                endcase
                fetch_check("R4 R5 R6 R7 R8 random fetch", pc, 1'($urandom_range(0, 3) != 0));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule